// File: doc/BRIEF.md
# Delayed Transaction Target Controller

This block sits on the target side of a shared bus and turns an access that is too slow to finish within the bus's first-data latency limit into a delayed transaction. When a new request is accepted and no entry is held, the block latches the request's address, command, byte enables and write data. It answers the initiator with a retry, which transfers no data, and starts the access on a back-end port. When the back-end finishes, the block keeps the completion status and the read data. It then waits for the same request to come back.

Only one delayed entry exists at a time. While it is pending or waiting to be claimed, every other request gets a retry and is not captured. A re-issued request that matches the entry exactly receives the stored result, and the entry is freed. If nobody claims a finished entry within a parameterised number of clocks, the entry is dropped. The bus side uses a valid/ready request channel and a valid/ready response channel. A request is only accepted while no response is waiting, so a stalled response consumer stalls the request channel. A response, once raised, holds its value until it is taken. The back-end uses a level request that stays high until a one-cycle done pulse.

Top module: `dtc_target`

## Requirements
- R1: After reset, rsp_valid and be_req are low and req_ready is high.
- R2: A request accepted while no entry is held is captured. The clock after acceptance, rsp_valid rises with rsp_code 0 (retry) and rsp_rdata 0, and be_req rises.
- R3: While be_req is high, be_addr, be_cmd, be_be and be_wdata carry the captured request and do not change. be_req falls the clock after be_done is sampled high.
- R4: A matching request accepted while the back-end access is still running receives a retry and leaves the entry unchanged.
- R5: A non-matching request accepted while an entry is pending or completed receives a retry and is not captured. The back-end fields do not change, and no new back-end request starts.
- R6: Bit 0 of the command is 1 for a write and 0 for a read. A match needs equal address, command and byte enables. For writes the write data must also be equal; for reads the write data is ignored.
- R7: A matching request accepted after the back-end completed without error receives rsp_code 1 (done). rsp_rdata carries the stored read data for a read and 0 for a write. The entry is then freed, so the next new request is captured.
- R8: When the back-end completed with be_err high, the matching request receives rsp_code 2 (abort) and the entry is freed.
- R9: A completed entry stays claimable for DISCARD_CLKS clocks after be_done. A matching request accepted at the last of those edges is still served. After that the entry is dropped and the same request is treated as new.
- R10: req_ready is low while rsp_valid is high. A response not taken because rsp_ready is low keeps rsp_valid, rsp_code and rsp_rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | AW | Request address |
| req_cmd | input | 4 | Request command, bit 0 = write |
| req_be | input | 4 | Request byte enables |
| req_wdata | input | DW | Request write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_code | output | 2 | 0 retry, 1 done, 2 abort |
| rsp_rdata | output | DW | Read data for a done read, else 0 |
| be_req | output | 1 | Back-end access in progress |
| be_addr | output | AW | Captured address |
| be_cmd | output | 4 | Captured command |
| be_be | output | 4 | Captured byte enables |
| be_wdata | output | DW | Captured write data |
| be_done | input | 1 | Back-end finished (one-cycle pulse) |
| be_err | input | 1 | Back-end error, valid with be_done |
| be_rdata | input | DW | Back-end read data, valid with be_done |

## Verification
The bench targets several corner cases. A read re-issued with different write data must still be claimed; a design that compared write data on reads would retry it forever. A write re-issued with different data must be retried; a design that skipped the data compare would hand one initiator's completion to another. The discard window is probed at its last claimable edge and one edge later. An off-by-one timer would either lose a legitimate claim or serve a stale result. Requests from other initiators during the pending and completed phases must not overwrite the entry or restart the back-end, and a stalled response must freeze the request channel.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_COMP = 2'd2
  } dtc_state_t;

  localparam logic [1:0] RSP_RETRY = 2'd0;
  localparam logic [1:0] RSP_DONE  = 2'd1;
  localparam logic [1:0] RSP_ABORT = 2'd2;

  localparam int CMD_W     = 4;
  localparam int BE_W      = 4;
  localparam int WRITE_BIT = 0;
endpackage

// File: rtl/dtc_match.sv
module dtc_match #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [AW-1:0]           a_addr,
  input  logic [dtc_pkg::CMD_W-1:0] a_cmd,
  input  logic [dtc_pkg::BE_W-1:0]  a_be,
  input  logic [DW-1:0]           a_wdata,
  input  logic [AW-1:0]           b_addr,
  input  logic [dtc_pkg::CMD_W-1:0] b_cmd,
  input  logic [dtc_pkg::BE_W-1:0]  b_be,
  input  logic [DW-1:0]           b_wdata,
  output logic                    hit
);
  logic hdr_eq;
  logic data_ok;

  assign hdr_eq  = (a_addr == b_addr) && (a_cmd == b_cmd) && (a_be == b_be);
  // read requests carry no meaningful write data
  assign data_ok = !a_cmd[dtc_pkg::WRITE_BIT] || (a_wdata == b_wdata);
  assign hit     = hdr_eq && data_ok;
endmodule

// File: rtl/dtc_discard_timer.sv
module dtc_discard_timer #(
  parameter int LIMIT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int TW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);
endmodule

// File: rtl/dtc_target.sv
module dtc_target #(
  parameter int AW           = 32,
  parameter int DW           = 32,
  parameter int DISCARD_CLKS = 32768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_cmd,
  input  logic [3:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [1:0]    rsp_code,
  output logic [DW-1:0] rsp_rdata,
  output logic          be_req,
  output logic [AW-1:0] be_addr,
  output logic [3:0]    be_cmd,
  output logic [3:0]    be_be,
  output logic [DW-1:0] be_wdata,
  input  logic          be_done,
  input  logic          be_err,
  input  logic [DW-1:0] be_rdata
);
  import dtc_pkg::*;

  dtc_state_t    state;
  logic [AW-1:0] e_addr;
  logic [3:0]    e_cmd;
  logic [3:0]    e_be;
  logic [DW-1:0] e_wdata;
  logic          c_err;
  logic [DW-1:0] c_rdata;

  logic          accept, hit, claim, expire, fin;
  logic [1:0]    nxt_code;
  logic [DW-1:0] nxt_rdata;

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign fin       = (state == ST_PEND) && be_done;

  dtc_match #(.AW(AW), .DW(DW)) u_match (
    .a_addr (e_addr),  .a_cmd (e_cmd),   .a_be (e_be),   .a_wdata (e_wdata),
    .b_addr (req_addr), .b_cmd (req_cmd), .b_be (req_be), .b_wdata (req_wdata),
    .hit    (hit)
  );

  dtc_discard_timer #(.LIMIT(DISCARD_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (fin),
    .run    (state == ST_COMP),
    .expire (expire)
  );

  assign claim = (state == ST_COMP) && hit;

  always_comb begin
    nxt_code  = RSP_RETRY;
    nxt_rdata = '0;
    if (claim) begin
      nxt_code = c_err ? RSP_ABORT : RSP_DONE;
      if (!c_err && !e_cmd[WRITE_BIT]) nxt_rdata = c_rdata;
    end
  end

  // entry state machine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      e_addr  <= '0;
      e_cmd   <= '0;
      e_be    <= '0;
      e_wdata <= '0;
      c_err   <= 1'b0;
      c_rdata <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          e_addr  <= req_addr;
          e_cmd   <= req_cmd;
          e_be    <= req_be;
          e_wdata <= req_wdata;
          state   <= ST_PEND;
        end
        ST_PEND: if (be_done) begin
          c_err   <= be_err;
          c_rdata <= be_rdata;
          state   <= ST_COMP;
        end
        ST_COMP: if ((accept && claim) || expire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_RETRY;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_code  <= nxt_code;
      rsp_rdata <= nxt_rdata;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign be_req   = (state == ST_PEND);
  assign be_addr  = e_addr;
  assign be_cmd   = e_cmd;
  assign be_be    = e_be;
  assign be_wdata = e_wdata;
endmodule

// File: rtl/dtc_target_chk.sv
module dtc_target_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_code,
  input logic [DW-1:0] rsp_rdata,
  input logic          be_req,
  input logic          be_done,
  input logic [AW-1:0] be_addr,
  input logic [3:0]    be_cmd,
  input logic [3:0]    be_be,
  input logic [DW-1:0] be_wdata
);
  p_first_retry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(be_req) |-> (rsp_valid && rsp_code == 2'd0));

  p_be_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_done) |=> (be_req && $stable(be_addr) && $stable(be_cmd)
                              && $stable(be_be) && $stable(be_wdata)));

  p_be_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && be_done) |=> !be_req);

  p_busy_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && req_valid && req_ready) |=> (rsp_valid && rsp_code == 2'd0));

  p_retry_nodata_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd0) |-> (rsp_rdata == '0));

  p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_rdata)));
endmodule

bind dtc_target dtc_target_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
  .rsp_rdata(rsp_rdata), .be_req(be_req), .be_done(be_done),
  .be_addr(be_addr), .be_cmd(be_cmd), .be_be(be_be), .be_wdata(be_wdata)
);

// File: tb/dtc_target_bench.sv
module dtc_target_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int D  = 20;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, rsp_ready = 1, be_done = 0, be_err = 0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_cmd = '0, req_be = '0;
  logic [DW-1:0] req_wdata = '0, be_rdata = '0;
  logic req_ready, rsp_valid, be_req;
  logic [1:0] rsp_code;
  logic [DW-1:0] rsp_rdata, be_wdata;
  logic [AW-1:0] be_addr;
  logic [3:0] be_cmd, be_be;

  int checks = 0, errors = 0;
  bit fin = 0;

  always #10 clk = ~clk;

  dtc_target #(.AW(AW), .DW(DW), .DISCARD_CLKS(D)) u_dtc_target (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_rdata(rsp_rdata), .be_req(be_req), .be_addr(be_addr), .be_cmd(be_cmd),
    .be_be(be_be), .be_wdata(be_wdata), .be_done(be_done), .be_err(be_err),
    .be_rdata(be_rdata)
  );

  // behavioural reference: 0 idle, 1 pending, 2 completed
  int m_state = 0, m_timer = 0;
  logic [AW-1:0] m_addr; logic [3:0] m_cmd, m_be; logic [DW-1:0] m_wd;
  logic m_err; logic [DW-1:0] m_data;
  logic m_rv = 0; logic [1:0] m_code = 0; logic [DW-1:0] m_rd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_rv = 0; m_code = 0; m_rd = 0; m_timer = 0;
    end else begin
      bit acc, same;
      acc  = req_valid && !m_rv;
      same = (req_addr == m_addr) && (req_cmd == m_cmd) && (req_be == m_be)
             && (!req_cmd[0] || req_wdata == m_wd);
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc) begin m_rv = 1; m_code = 0; m_rd = 0; end
      if (m_state == 0) begin
        if (acc) begin
          m_addr = req_addr; m_cmd = req_cmd; m_be = req_be; m_wd = req_wdata;
          m_state = 1;
        end
      end else if (m_state == 1) begin
        if (be_done) begin m_state = 2; m_err = be_err; m_data = be_rdata; m_timer = 0; end
      end else begin
        if (acc && same) begin
          m_code = m_err ? 2'd2 : 2'd1;
          m_rd = (!m_err && !m_cmd[0]) ? m_data : '0;
          m_state = 0;
        end else if (m_timer == D - 1) m_state = 0;
        else m_timer++;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      check("R10 req_ready model", req_ready, !m_rv);
      check("R2 rsp_valid model", rsp_valid, m_rv);
      if (m_rv) begin
        check("R7 rsp_code model", rsp_code, m_code);
        check("R7 rsp_rdata model", rsp_rdata, m_rd);
      end
      check("R3 be_req model", be_req, m_state == 1);
      if (m_state == 1) begin
        check("R3 be_addr model", be_addr, m_addr);
        check("R3 be_cmd model", be_cmd, m_cmd);
        check("R3 be_wdata model", be_wdata, m_wd);
      end
    end
  end

  task automatic send(input logic [AW-1:0] a, input logic [3:0] c, input logic [DW-1:0] w);
    if (rsp_valid) @(negedge clk);
    req_addr = a; req_cmd = c; req_be = 4'hF; req_wdata = w; req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_be(input logic err, input logic [DW-1:0] d);
    be_err = err; be_rdata = d; be_done = 1;
    @(negedge clk);
    be_done = 0;
  endtask

  localparam logic [3:0] RD = 4'h6, WR = 4'h7;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 be_req", be_req, 0);
    check("R1 req_ready", req_ready, 1);

    send(32'hA0, RD, 32'h1);
    check("R2 first retry", rsp_code, 0);
    check("R2 be_req up", be_req, 1);
    check("R3 be_addr", be_addr, 32'hA0);
    repeat (2) @(negedge clk);
    send(32'hA0, RD, 32'h1);
    check("R4 match while pending", rsp_code, 0);
    send(32'hB0, RD, 32'h0);
    check("R5 other retried", rsp_code, 0);
    check("R5 entry kept", be_addr, 32'hA0);
    finish_be(0, 32'hDEAD_BEEF);
    send(32'hB0, RD, 32'h0);
    check("R5 other while complete", rsp_code, 0);
    check("R5 no new capture", be_req, 0);
    send(32'hA0, RD, 32'h55);
    check("R6 read ignores wdata", rsp_code, 1);
    check("R7 read data", rsp_rdata, 32'hDEAD_BEEF);

    send(32'hC0, WR, 32'h1234);
    check("R7 freed, new capture", be_req, 1);
    check("R7 new addr", be_addr, 32'hC0);
    finish_be(1, 32'h99);
    send(32'hC0, WR, 32'h1235);
    check("R6 write data differs", rsp_code, 0);
    send(32'hC0, WR, 32'h1234);
    check("R8 abort", rsp_code, 2);
    check("R8 abort no data", rsp_rdata, 0);

    send(32'hD0, WR, 32'h7);
    finish_be(0, 32'h0);
    repeat (D - 1) @(negedge clk);
    send(32'hD0, WR, 32'h7);
    check("R9 last edge claim", rsp_code, 1);
    check("R7 write done no data", rsp_rdata, 0);

    send(32'hE0, RD, 32'h0);
    finish_be(0, 32'h42);
    repeat (D) @(negedge clk);
    send(32'hE0, RD, 32'h0);
    check("R9 discarded retry", rsp_code, 0);
    check("R9 recaptured", be_req, 1);

    @(negedge clk);
    rsp_ready = 0;
    send(32'hF0, RD, 32'h0);
    repeat (3) @(negedge clk);
    check("R10 held valid", rsp_valid, 1);
    check("R10 ready low", req_ready, 0);
    check("R10 held code", rsp_code, 0);
    rsp_ready = 1;
    repeat (3) @(negedge clk);

    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule